// File: doc/BRIEF.md
# Layer 4 Port Filter

This block watches a received Ethernet frame as a byte stream and gives a pass or fail verdict on it. The verdict depends on the TCP or UDP port numbers that the frame carries. The block checks that the frame is IPv4 by its EtherType and its version and header-length byte. It then uses the header length to find the transport header and takes the 16-bit source and destination ports from it. Each port is compared with a programmed value. The configuration inputs control each port separately: an enable and a sense bit for each one. When an enabled port's sense bit is clear, the port must equal the programmed value. When the sense bit is set, the port must differ from it. A single select bit decides whether TCP or UDP frames are examined.

If neither port enable is set, the filter is bypassed and every frame passes. One cycle after the last byte of a frame is accepted, the block raises a one-cycle verdict strobe with the pass flag beside it. The configuration is sampled in the cycle that the last byte is accepted. A receive path uses the verdict to keep or discard the frame it has buffered.

Top module: `l4_port_filter`

## Requirements
- R1: While filtering is active, a frame fails unless all of these hold: bytes 12 and 13 read 0x08 then 0x00; the high nibble of byte 14 is 4; the low nibble of byte 14 (the header length in 32-bit words) is at least 5.
- R2: The transport header starts at byte 14 + 4 × header length. The source port is transport bytes 0 and 1, and the destination port is transport bytes 2 and 3. Both are most significant byte first.
- R3: With `cfgUdpSel` = 1, only frames whose IP protocol byte (byte 23) is 17 can pass. With `cfgUdpSel` = 0, only protocol 6 can pass.
- R4: With `cfgSrcEn` = 0, the source port has no effect on the verdict, whatever its value and whatever `cfgSrcInv` holds.
- R5: With `cfgSrcEn` = 1, the source field passes on equality with `cfgSrcPort` when `cfgSrcInv` = 0. It passes on inequality when `cfgSrcInv` = 1.
- R6: `cfgDstEn` and `cfgDstInv` act on the destination port against `cfgDstPort` in the same way as the R4 and R5 bits act on the source port.
- R7: While filtering is active, a frame passes only if every enabled port field passes and the R1 and R3 conditions hold.
- R8: When both `cfgSrcEn` and `cfgDstEn` are 0, every frame passes, including non-IPv4 frames and frames that are too short.
- R9: `verdictValid` is high for exactly the one cycle after the cycle in which a byte with `inValid` = 1 and `inEof` = 1 is accepted, and is low at all other times. `verdictPass` is high only together with `verdictValid`.
- R10: While filtering is active, a frame that ends before its destination-port low byte fails. A frame whose last byte is that low byte is judged in full.
- R11: During and after reset, both outputs are 0 until the first frame ends.
- R12: Cycles with `inValid` = 0 are ignored, whatever `inByte`, `inSof` and `inEof` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Byte qualifier |
| inByte | input | 8 | Frame byte |
| inSof | input | 1 | First byte of a frame |
| inEof | input | 1 | Last byte of a frame |
| cfgSrcEn | input | 1 | Source port takes part in matching |
| cfgSrcInv | input | 1 | Source port sense: 1 = must differ |
| cfgDstEn | input | 1 | Destination port takes part in matching |
| cfgDstInv | input | 1 | Destination port sense: 1 = must differ |
| cfgUdpSel | input | 1 | 1 = UDP (17), 0 = TCP (6) |
| cfgSrcPort | input | 16 | Source port comparison value |
| cfgDstPort | input | 16 | Destination port comparison value |
| verdictValid | output | 1 | One-cycle verdict strobe |
| verdictPass | output | 1 | Frame passed the filter |

## Verification
Two functions can fall in the same cycle. The first case is a frame whose last byte is the destination-port low byte, so capturing that byte and forming the verdict happen together. The bench provokes this with frames of exactly transport offset plus four bytes, and it checks that the verdict uses the byte arriving on that edge. The second case is back-to-back frames, where the verdict of one frame is still pending while the first byte of the next is accepted. The bench streams frames with no idle cycle between them and judges each strobe against its own frame's expected result.

// File: rtl/l4pf_pkg.sv
package l4pf_pkg;
  localparam int ETH_HDR_LEN = 14;
  localparam int IP_PROTO_OFS = 9;
  localparam logic [7:0] ETYPE_HI = 8'h08;
  localparam logic [7:0] ETYPE_LO = 8'h00;
  localparam logic [7:0] PROTO_TCP = 8'd6;
  localparam logic [7:0] PROTO_UDP = 8'd17;

  typedef struct packed {
    logic clr;
    logic etHi;
    logic etLo;
    logic verIhl;
    logic proto;
    logic srcHi;
    logic srcLo;
    logic dstHi;
    logic dstLo;
    logic fin;
  } l4pf_strobe_t;
endpackage

// File: rtl/l4pf_ctrl.sv
module l4pf_ctrl
  import l4pf_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic         inSof,
  input  logic         inEof,
  input  logic [3:0]   ihl,
  input  logic         hdrOk,
  output l4pf_strobe_t strb
);
  localparam logic [POS_W-1:0] POS_MAX   = '1;
  localparam logic [POS_W-1:0] POS_ET_HI = POS_W'(ETH_HDR_LEN - 2);
  localparam logic [POS_W-1:0] POS_ET_LO = POS_W'(ETH_HDR_LEN - 1);
  localparam logic [POS_W-1:0] POS_VIHL  = POS_W'(ETH_HDR_LEN);
  localparam logic [POS_W-1:0] POS_PROTO = POS_W'(ETH_HDR_LEN + IP_PROTO_OFS);

  logic [POS_W-1:0] cnt;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] base;

  assign pos  = inSof ? '0 : cnt;
  assign base = POS_W'(ETH_HDR_LEN) + POS_W'({ihl, 2'b00});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (inValid) begin
      cnt <= (pos == POS_MAX) ? pos : pos + 1'b1;
    end
  end

  always_comb begin
    strb        = '0;
    strb.clr    = inValid && inSof;
    strb.etHi   = inValid && (pos == POS_ET_HI);
    strb.etLo   = inValid && (pos == POS_ET_LO);
    strb.verIhl = inValid && (pos == POS_VIHL);
    strb.proto  = inValid && (pos == POS_PROTO);
    strb.srcHi  = inValid && hdrOk && (pos == base);
    strb.srcLo  = inValid && hdrOk && (pos == base + POS_W'(1));
    strb.dstHi  = inValid && hdrOk && (pos == base + POS_W'(2));
    strb.dstLo  = inValid && hdrOk && (pos == base + POS_W'(3));
    strb.fin    = inValid && inEof;
  end
endmodule

// File: rtl/l4pf_dpath.sv
module l4pf_dpath
  import l4pf_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   inByte,
  input  l4pf_strobe_t strb,
  input  logic         cfgSrcEn,
  input  logic         cfgSrcInv,
  input  logic         cfgDstEn,
  input  logic         cfgDstInv,
  input  logic         cfgUdpSel,
  input  logic [15:0]  cfgSrcPort,
  input  logic [15:0]  cfgDstPort,
  output logic [3:0]   ihl,
  output logic         hdrOk,
  output logic         verdictValid,
  output logic         verdictPass
);
  logic        etHiOk, etOk, gotDst;
  logic [7:0]  protoReg, dstHiReg;
  logic [15:0] srcReg, dstReg;

  logic        etHiOkN, etOkN, hdrOkN, gotDstN;
  logic [3:0]  ihlN;
  logic [7:0]  protoN, dstHiN;
  logic [15:0] srcN, dstN;
  logic        filterOn, srcOk, dstOk, l4Ok, passN;
  logic [7:0]  wantProto;

  always_comb begin
    etHiOkN = strb.clr ? 1'b0 : etHiOk;
    etOkN   = strb.clr ? 1'b0 : etOk;
    hdrOkN  = strb.clr ? 1'b0 : hdrOk;
    ihlN    = strb.clr ? 4'd0 : ihl;
    protoN  = strb.clr ? 8'd0 : protoReg;
    gotDstN = strb.clr ? 1'b0 : gotDst;
    srcN    = srcReg;
    dstHiN  = dstHiReg;
    dstN    = dstReg;
    if (strb.etHi)   etHiOkN = (inByte == ETYPE_HI);
    if (strb.etLo)   etOkN   = etHiOkN && (inByte == ETYPE_LO);
    if (strb.verIhl) begin
      hdrOkN = (inByte[7:4] == 4'd4) && (inByte[3:0] >= 4'd5);
      ihlN   = inByte[3:0];
    end
    if (strb.proto)  protoN = inByte;
    if (strb.srcHi)  srcN   = {inByte, srcReg[7:0]};
    if (strb.srcLo)  srcN   = {srcReg[15:8], inByte};
    if (strb.dstHi)  dstHiN = inByte;
    if (strb.dstLo) begin
      dstN    = {dstHiReg, inByte};
      gotDstN = 1'b1;
    end
  end

  always_comb begin
    filterOn  = cfgSrcEn || cfgDstEn;
    wantProto = cfgUdpSel ? PROTO_UDP : PROTO_TCP;
    srcOk     = !cfgSrcEn || ((srcN == cfgSrcPort) != cfgSrcInv);
    dstOk     = !cfgDstEn || ((dstN == cfgDstPort) != cfgDstInv);
    l4Ok      = etOkN && hdrOkN && (protoN == wantProto) && gotDstN && srcOk && dstOk;
    passN     = !filterOn || l4Ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      etHiOk       <= 1'b0;
      etOk         <= 1'b0;
      hdrOk        <= 1'b0;
      ihl          <= 4'd0;
      protoReg     <= 8'd0;
      gotDst       <= 1'b0;
      srcReg       <= 16'd0;
      dstHiReg     <= 8'd0;
      dstReg       <= 16'd0;
      verdictValid <= 1'b0;
      verdictPass  <= 1'b0;
    end else begin
      etHiOk       <= etHiOkN;
      etOk         <= etOkN;
      hdrOk        <= hdrOkN;
      ihl          <= ihlN;
      protoReg     <= protoN;
      gotDst       <= gotDstN;
      srcReg       <= srcN;
      dstHiReg     <= dstHiN;
      dstReg       <= dstN;
      verdictValid <= strb.fin;
      verdictPass  <= strb.fin && passN;
    end
  end
endmodule

// File: rtl/l4_port_filter.sv
module l4_port_filter
  import l4pf_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [7:0]  inByte,
  input  logic        inSof,
  input  logic        inEof,
  input  logic        cfgSrcEn,
  input  logic        cfgSrcInv,
  input  logic        cfgDstEn,
  input  logic        cfgDstInv,
  input  logic        cfgUdpSel,
  input  logic [15:0] cfgSrcPort,
  input  logic [15:0] cfgDstPort,
  output logic        verdictValid,
  output logic        verdictPass
);
  l4pf_strobe_t strb;
  logic [3:0]   ihl;
  logic         hdrOk;

  l4pf_ctrl #(.POS_W(POS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .ihl(ihl), .hdrOk(hdrOk), .strb(strb)
  );

  l4pf_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .inByte(inByte), .strb(strb),
    .cfgSrcEn(cfgSrcEn), .cfgSrcInv(cfgSrcInv), .cfgDstEn(cfgDstEn),
    .cfgDstInv(cfgDstInv), .cfgUdpSel(cfgUdpSel),
    .cfgSrcPort(cfgSrcPort), .cfgDstPort(cfgDstPort),
    .ihl(ihl), .hdrOk(hdrOk),
    .verdictValid(verdictValid), .verdictPass(verdictPass)
  );
endmodule

// File: rtl/l4pf_checker.sv
module l4pf_checker (
  input logic clk,
  input logic rst_n,
  input logic inValid,
  input logic inEof,
  input logic cfgSrcEn,
  input logic cfgDstEn,
  input logic verdictValid,
  input logic verdictPass
);
  // R9: a strobe follows every accepted last byte
  a_r9_verdict_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inEof) |=> verdictValid);

  // R9, R12: no strobe without an accepted last byte
  a_r9_verdict_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    verdictValid |-> $past(inValid && inEof));

  // R9: pass flag only beside the strobe
  a_r9_pass_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    verdictPass |-> verdictValid);

  // R8: bypass passes everything
  a_r8_bypass_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (verdictValid && !$past(cfgSrcEn || cfgDstEn)) |-> verdictPass);
endmodule

bind l4_port_filter l4pf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inEof(inEof),
  .cfgSrcEn(cfgSrcEn), .cfgDstEn(cfgDstEn),
  .verdictValid(verdictValid), .verdictPass(verdictPass)
);

// File: tb/l4_port_filter_test.sv
`timescale 1ns/1ps
module l4_port_filter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [7:0] inByte = 8'd0;
  logic cfgSrcEn = 0, cfgSrcInv = 0, cfgDstEn = 0, cfgDstInv = 0, cfgUdpSel = 0;
  logic [15:0] cfgSrcPort = 16'd0, cfgDstPort = 16'd0;
  logic verdictValid, verdictPass;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  l4_port_filter uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inByte(inByte),
    .inSof(inSof), .inEof(inEof), .cfgSrcEn(cfgSrcEn), .cfgSrcInv(cfgSrcInv),
    .cfgDstEn(cfgDstEn), .cfgDstInv(cfgDstInv), .cfgUdpSel(cfgUdpSel),
    .cfgSrcPort(cfgSrcPort), .cfgDstPort(cfgDstPort),
    .verdictValid(verdictValid), .verdictPass(verdictPass)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired: actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // frame image and stream queue
  logic [7:0] frm [0:127];
  logic [7:0] sByte [0:1023];
  logic       sVal [0:1023];
  logic       sSof [0:1023];
  logic       sEof [0:1023];
  int         nb = 0;
  logic       expQ [0:31];
  string      tagQ [0:31];
  int         ne = 0;

  task automatic mkFrame(input logic [15:0] et, input logic [3:0] ver,
                         input logic [3:0] ihl, input logic [7:0] proto,
                         input logic [15:0] sp, input logic [15:0] dp);
    int b;
    for (int i = 0; i < 128; i++) frm[i] = 8'(i) ^ 8'h5A;
    b = 14 + 4 * int'(ihl);
    frm[12] = et[15:8];
    frm[13] = et[7:0];
    frm[14] = {ver, ihl};
    frm[23] = proto;
    if (b + 3 < 128) begin
      frm[b]   = sp[15:8];
      frm[b+1] = sp[7:0];
      frm[b+2] = dp[15:8];
      frm[b+3] = dp[7:0];
    end
  endtask

  // model written from the requirements
  function automatic logic refPass(input logic [15:0] et, input logic [3:0] ver,
                                   input logic [3:0] ihl, input logic [7:0] proto,
                                   input logic [15:0] sp, input logic [15:0] dp,
                                   input int len);
    logic ok;
    if (!cfgSrcEn && !cfgDstEn) return 1'b1;
    ok = (et == 16'h0800) && (ver == 4'd4) && (ihl >= 4'd5) && (len >= 24);
    ok = ok && (proto == (cfgUdpSel ? 8'd17 : 8'd6));
    ok = ok && (len >= 14 + 4 * int'(ihl) + 4);
    if (cfgSrcEn) ok = ok && (cfgSrcInv ? (sp != cfgSrcPort) : (sp == cfgSrcPort));
    if (cfgDstEn) ok = ok && (cfgDstInv ? (dp != cfgDstPort) : (dp == cfgDstPort));
    return ok;
  endfunction

  task automatic addFrame(input logic [15:0] et, input logic [3:0] ver,
                          input logic [3:0] ihl, input logic [7:0] proto,
                          input logic [15:0] sp, input logic [15:0] dp,
                          input int len, input int gapAt, input string tag);
    mkFrame(et, ver, ihl, proto, sp, dp);
    for (int i = 0; i < len; i++) begin
      if (i == gapAt) begin
        sByte[nb] = 8'hFF; sVal[nb] = 1'b0; sSof[nb] = 1'b1; sEof[nb] = 1'b1; nb++;
      end
      sByte[nb] = frm[i]; sVal[nb] = 1'b1;
      sSof[nb] = (i == 0); sEof[nb] = (i == len - 1); nb++;
    end
    expQ[ne] = refPass(et, ver, ihl, proto, sp, dp, len);
    tagQ[ne] = tag;
    ne++;
  endtask

  task automatic runStream();
    int k = 0;
    logic prevFin = 1'b0;
    for (int idx = 0; idx <= nb; idx++) begin
      @(negedge clk);
      if (prevFin) begin
        checks++;
        if (verdictValid !== 1'b1 || verdictPass !== expQ[k]) begin
          errors++;
          $display("FAIL %s frame %0d: actual valid=%b pass=%b expected valid=1 pass=%b",
                   tagQ[k], k, verdictValid, verdictPass, expQ[k]);
        end
        k++;
      end else if (verdictValid !== 1'b0) begin
        checks++;
        errors++;
        $display("FAIL R9 spurious strobe: actual valid=%b expected valid=0", verdictValid);
      end
      if (idx < nb) begin
        inValid = sVal[idx]; inByte = sByte[idx]; inSof = sSof[idx]; inEof = sEof[idx];
        prevFin = sVal[idx] && sEof[idx];
      end else begin
        inValid = 1'b0; inByte = 8'h00; inSof = 1'b0; inEof = 1'b0;
        prevFin = 1'b0;
      end
    end
    @(negedge clk);
    checks++;
    if (verdictValid !== 1'b0) begin
      errors++;
      $display("FAIL R9 strobe longer than one cycle: actual %b expected 0", verdictValid);
    end
    nb = 0;
    ne = 0;
  endtask

  task automatic setCfg(input logic se, input logic si, input logic de, input logic di,
                        input logic udp, input logic [15:0] sp, input logic [15:0] dp);
    cfgSrcEn = se; cfgSrcInv = si; cfgDstEn = de; cfgDstInv = di;
    cfgUdpSel = udp; cfgSrcPort = sp; cfgDstPort = dp;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (verdictValid !== 1'b0 || verdictPass !== 1'b0) begin
      errors++;
      $display("FAIL R11 in reset: actual %b%b expected 00", verdictValid, verdictPass);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (verdictValid !== 1'b0 || verdictPass !== 1'b0) begin
      errors++;
      $display("FAIL R11 after reset: actual %b%b expected 00", verdictValid, verdictPass);
    end
  endtask

  task automatic t_bypass();
    setCfg(0, 1, 0, 1, 0, 16'h1234, 16'h0050);
    addFrame(16'h0800, 4, 5, 6, 16'h9999, 16'h8888, 60, -1, "R8 tcp");
    addFrame(16'h0806, 4, 5, 6, 16'h1234, 16'h0050, 42, -1, "R8 non-ip");
    addFrame(16'h0800, 4, 5, 6, 16'h1234, 16'h0050, 20, -1, "R8 short");
    runStream();
  endtask

  task automatic t_src();
    setCfg(1, 0, 0, 1, 0, 16'h1F90, 16'h0050);
    addFrame(16'h0800, 4, 5, 6, 16'h1F90, 16'hAAAA, 64, -1, "R5 R4 exact src");
    addFrame(16'h0800, 4, 5, 6, 16'h1F91, 16'h0050, 64, -1, "R5 src differs");
    addFrame(16'h0800, 4, 7, 6, 16'h1F90, 16'h0001, 64, -1, "R2 ihl7 src");
    runStream();
    setCfg(1, 1, 0, 0, 0, 16'h1F90, 16'h0050);
    addFrame(16'h0800, 4, 5, 6, 16'h1F90, 16'h0050, 64, -1, "R5 inverse equal");
    addFrame(16'h0800, 4, 5, 6, 16'h1F90 ^ 16'h8000, 16'h0050, 64, -1, "R5 inverse differ");
    runStream();
  endtask

  task automatic t_dst();
    setCfg(0, 1, 1, 0, 0, 16'h0000, 16'h01BB);
    addFrame(16'h0800, 4, 5, 6, 16'h0000, 16'h01BB, 64, -1, "R6 exact dst");
    addFrame(16'h0800, 4, 5, 6, 16'h4321, 16'h01BB, 64, -1, "R4 src ignored");
    addFrame(16'h0800, 4, 5, 6, 16'h0000, 16'hBB01, 64, -1, "R6 swapped bytes");
    runStream();
    setCfg(0, 0, 1, 1, 0, 16'h0000, 16'h01BB);
    addFrame(16'h0800, 4, 5, 6, 16'h0000, 16'h01BB, 64, -1, "R6 inverse equal");
    addFrame(16'h0800, 4, 6, 6, 16'h0000, 16'h01BC, 64, -1, "R6 R2 inverse differ ihl6");
    runStream();
  endtask

  task automatic t_and();
    setCfg(1, 0, 1, 1, 0, 16'h2000, 16'h3000);
    addFrame(16'h0800, 4, 5, 6, 16'h2000, 16'h3001, 64, -1, "R7 both ok");
    addFrame(16'h0800, 4, 5, 6, 16'h2001, 16'h3001, 64, -1, "R7 src bad");
    addFrame(16'h0800, 4, 5, 6, 16'h2000, 16'h3000, 64, -1, "R7 dst bad");
    runStream();
  endtask

  task automatic t_proto();
    setCfg(1, 0, 0, 0, 1, 16'h0035, 16'h0000);
    addFrame(16'h0800, 4, 5, 17, 16'h0035, 16'h0000, 64, -1, "R3 udp selected");
    addFrame(16'h0800, 4, 5, 6, 16'h0035, 16'h0000, 64, -1, "R3 tcp when udp");
    runStream();
    setCfg(1, 0, 0, 0, 0, 16'h0035, 16'h0000);
    addFrame(16'h0800, 4, 5, 17, 16'h0035, 16'h0000, 64, -1, "R3 udp when tcp");
    addFrame(16'h0800, 4, 5, 1, 16'h0035, 16'h0000, 64, -1, "R3 icmp");
    runStream();
  endtask

  task automatic t_nonip();
    setCfg(1, 1, 0, 0, 0, 16'h0000, 16'h0000);
    addFrame(16'h86DD, 4, 5, 6, 16'h1111, 16'h0000, 64, -1, "R1 ethertype");
    addFrame(16'h0801, 4, 5, 6, 16'h1111, 16'h0000, 64, -1, "R1 ethertype low");
    addFrame(16'h0800, 6, 5, 6, 16'h1111, 16'h0000, 64, -1, "R1 version");
    addFrame(16'h0800, 4, 4, 6, 16'h1111, 16'h0000, 64, -1, "R1 ihl4");
    addFrame(16'h0800, 4, 5, 6, 16'h1111, 16'h0000, 64, -1, "R1 good");
    runStream();
  endtask

  task automatic t_short();
    setCfg(0, 0, 1, 0, 0, 16'h0000, 16'hC0DE);
    addFrame(16'h0800, 4, 5, 6, 16'h0000, 16'hC0DE, 37, -1, "R10 ends before dst low");
    addFrame(16'h0800, 4, 5, 6, 16'h0000, 16'hC0DE, 38, -1, "R10 ends on dst low");
    addFrame(16'h0800, 4, 5, 6, 16'h0000, 16'hC0DF, 38, -1, "R10 ends on dst low miss");
    addFrame(16'h0800, 4, 5, 6, 16'h0000, 16'hC0DE, 1, -1, "R10 one byte");
    addFrame(16'h0800, 4, 8, 6, 16'h0000, 16'hC0DE, 49, -1, "R10 ihl8 short");
    addFrame(16'h0800, 4, 8, 6, 16'h0000, 16'hC0DE, 50, -1, "R10 R2 ihl8 exact");
    runStream();
  endtask

  task automatic t_gaps();
    setCfg(1, 0, 1, 0, 1, 16'hABCD, 16'h1357);
    addFrame(16'h0800, 4, 5, 17, 16'hABCD, 16'h1357, 40, 12, "R12 gap in ethertype");
    addFrame(16'h0800, 4, 5, 17, 16'hABCD, 16'h1357, 40, 36, "R12 gap in dst port");
    addFrame(16'h0800, 4, 5, 17, 16'hABCD, 16'h1356, 40, 35, "R12 gap miss");
    runStream();
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_src();
    t_dst();
    t_and();
    t_proto();
    t_nonip();
    t_short();
    t_gaps();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule